// File: doc/BRIEF.md
# Command-Gated Power-Down Controller

This block tracks the operating state of a processor that is driven by host commands, and it governs when that processor may sleep and how it wakes. A host-interface layer in front of it decodes the incoming bytes and hands over single-cycle strobes: one for a stop request, one for a power-down request, one for any other command that starts work, and one from the execution units when that work completes. The controller keeps three states, idle, busy and powered down, and allows sleep only from idle. A host that wants to sleep while work is in progress must stop the work first and then ask again.

While asleep, the controller drops the main-logic enable that feeds the clock gates of the non-essential units. The enables for memory refresh and for the real-time clock stay on in every state. Any strobe that arrives during sleep wakes the block. That strobe is used up as the wake event and starts no work. On the same transition the controller sends a one-cycle reset to every signal detector. A power-down request made while busy is dropped, and a one-cycle reject flag reports it.

Top module: `pwrdn_ctrl`

## Requirements
- R1: After reset, state_o is 0 (idle; the encoding is idle=0, busy=1, powered down=2), main_en is 1, and det_rst, pdm_reject and cmd_exec are all 0.
- R2: A cmd_pdm strobe in idle moves state_o to 2 at the next clock edge, and main_en reads 0 from that edge on.
- R3: In busy, a cmd_stop strobe or a cmd_done strobe returns state_o to 0 at the next edge.
- R4: In the powered-down state, a strobe on cmd_stop, cmd_pdm or cmd_other returns state_o to 0 at the next edge and raises no cmd_exec, because the waking command is consumed.
- R5: On the edge that leaves the powered-down state, every bit of det_rst rises. All bits fall again at the following edge.
- R6: refresh_en and rtc_en are 1 in every state. main_en is 0 only while state_o is 2.
- R7: A cmd_pdm strobe in busy never leads to the powered-down state, and it raises pdm_reject for exactly one cycle. If cmd_stop arrives in the same cycle, the stop still takes effect.
- R8: A cmd_other strobe in idle moves state_o to 1 and raises cmd_exec for one cycle. If cmd_pdm arrives in the same cycle in idle, the power-down request wins: state_o goes to 2 and cmd_exec stays 0.
- R9: A cmd_other strobe in busy has no effect: state_o stays 1 and cmd_exec stays 0.
- R10: A cmd_stop strobe in idle has no effect: state_o stays 0 and no flag rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_stop | input | 1 | Stop command strobe |
| cmd_pdm | input | 1 | Power-down command strobe |
| cmd_other | input | 1 | Strobe for any other command |
| cmd_done | input | 1 | Execution of the current command has finished |
| state_o | output | 2 | Current state: 0 idle, 1 busy, 2 powered down |
| main_en | output | 1 | Clock enable for the main logic |
| refresh_en | output | 1 | Memory refresh enable |
| rtc_en | output | 1 | Real-time clock and date update enable |
| det_rst | output | DET_W | Detector reset pulse, one bit per detector |
| pdm_reject | output | 1 | Power-down request was refused |
| cmd_exec | output | 1 | Command forwarded for execution |

## Verification
Two outcomes can land on the same edge. A refused power-down request can coincide with a stop that ends the busy state. The bench strobes cmd_pdm and cmd_stop together while busy and expects both pdm_reject high and state_o back at idle. It never expects the powered-down state. The wake-up path is also tested with cmd_pdm itself as the waking strobe. Here the bench expects idle plus the det_rst pulse and no re-entry into sleep. Finally, cmd_pdm and cmd_other arrive together in idle, and the power-down request must win.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_BUSY = 2'd1,
      ST_PDN  = 2'd2
   } pdc_state_e;

   typedef struct packed {
      logic stop;
      logic pdm;
      logic other;
      logic done;
   } pdc_cmd_t;
endpackage

// File: rtl/pdc_next_state.sv
module pdc_next_state
   import pdc_pkg::*;
(
   input  pdc_state_e cur,
   input  pdc_cmd_t   cmd,
   output pdc_state_e nxt,
   output logic       wake,
   output logic       reject,
   output logic       exec
);
   logic any_cmd;
   assign any_cmd = cmd.stop | cmd.pdm | cmd.other;

   always_comb begin
      nxt    = cur;
      wake   = 1'b0;
      reject = 1'b0;
      exec   = 1'b0;
      unique case (cur)
         ST_IDLE: begin
            if (cmd.pdm) begin
               nxt = ST_PDN;
            end else if (cmd.other) begin
               nxt  = ST_BUSY;
               exec = 1'b1;
            end
         end
         ST_BUSY: begin
            reject = cmd.pdm;
            if (cmd.stop || cmd.done) begin
               nxt = ST_IDLE;
            end
         end
         ST_PDN: begin
            if (any_cmd) begin
               nxt  = ST_IDLE;
               wake = 1'b1;
            end
         end
         default: nxt = ST_IDLE;
      endcase
   end
endmodule

// File: rtl/pdc_event_regs.sv
module pdc_event_regs #(
   parameter int DET_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wake,
   input  logic             reject,
   input  logic             exec,
   output logic [DET_W-1:0] det_rst,
   output logic             pdm_reject,
   output logic             cmd_exec
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pdm_reject <= 1'b0;
         cmd_exec   <= 1'b0;
      end else begin
         pdm_reject <= reject;
         cmd_exec   <= exec;
      end
   end

   for (genvar i = 0; i < DET_W; i++) begin : g_det
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) det_rst[i] <= 1'b0;
         else        det_rst[i] <= wake;
      end
   end
endmodule

// File: rtl/pdc_enable_gen.sv
module pdc_enable_gen
   import pdc_pkg::*;
#(
   parameter bit REG_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  pdc_state_e cur,
   input  pdc_state_e nxt,
   output logic       main_en,
   output logic       refresh_en,
   output logic       rtc_en
);
   assign refresh_en = 1'b1;
   assign rtc_en     = 1'b1;

   if (REG_EN) begin : g_reg
      logic en_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) en_q <= 1'b1;
         else        en_q <= (nxt != ST_PDN);
      end
      assign main_en = en_q;
      logic unused_cur;
      assign unused_cur = ^cur;
   end else begin : g_comb
      assign main_en = (cur != ST_PDN);
      logic unused_nxt;
      assign unused_nxt = ^{nxt, clk, rst_n};
   end
endmodule

// File: rtl/pwrdn_ctrl.sv
module pwrdn_ctrl
   import pdc_pkg::*;
#(
   parameter int DET_W  = 4,
   parameter bit REG_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_stop,
   input  logic             cmd_pdm,
   input  logic             cmd_other,
   input  logic             cmd_done,
   output logic [1:0]       state_o,
   output logic             main_en,
   output logic             refresh_en,
   output logic             rtc_en,
   output logic [DET_W-1:0] det_rst,
   output logic             pdm_reject,
   output logic             cmd_exec
);
   if (DET_W < 1 || DET_W > 64) begin : g_bad_det_w
      $error("pwrdn_ctrl: DET_W must lie in 1..64");
   end

   pdc_state_e state_q, state_d;
   pdc_cmd_t   cmd;
   logic       wake, reject, exec;

   assign cmd = '{stop: cmd_stop, pdm: cmd_pdm, other: cmd_other, done: cmd_done};

   pdc_next_state u_next (
      .cur    (state_q),
      .cmd    (cmd),
      .nxt    (state_d),
      .wake   (wake),
      .reject (reject),
      .exec   (exec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   pdc_event_regs #(.DET_W(DET_W)) u_events (
      .clk        (clk),
      .rst_n      (rst_n),
      .wake       (wake),
      .reject     (reject),
      .exec       (exec),
      .det_rst    (det_rst),
      .pdm_reject (pdm_reject),
      .cmd_exec   (cmd_exec)
   );

   pdc_enable_gen #(.REG_EN(REG_EN)) u_enables (
      .clk        (clk),
      .rst_n      (rst_n),
      .cur        (state_q),
      .nxt        (state_d),
      .main_en    (main_en),
      .refresh_en (refresh_en),
      .rtc_en     (rtc_en)
   );

   assign state_o = state_q;
endmodule

// File: rtl/pwrdn_ctrl_chk.sv
module pwrdn_ctrl_chk #(
   parameter int DET_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_stop,
   input logic             cmd_pdm,
   input logic             cmd_other,
   input logic             cmd_done,
   input logic [1:0]       state_o,
   input logic             main_en,
   input logic             refresh_en,
   input logic             rtc_en,
   input logic [DET_W-1:0] det_rst,
   input logic             pdm_reject,
   input logic             cmd_exec
);
   logic any_cmd;
   assign any_cmd = cmd_stop | cmd_pdm | cmd_other;

   p_idle_to_pdn_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd0 && cmd_pdm) |=> (state_o == 2'd2));

   p_busy_never_pdn_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd1 && cmd_pdm) |=> (state_o != 2'd2 && pdm_reject));

   p_busy_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd1 && (cmd_stop || cmd_done)) |=> (state_o == 2'd0));

   p_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd2 && any_cmd) |=> (state_o == 2'd0 && !cmd_exec && (&det_rst)));

   p_det_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      det_rst[0] |=> !det_rst[0]);

   p_main_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (main_en == (state_o != 2'd2)) && refresh_en && rtc_en);

   p_exec_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_exec |-> (state_o == 2'd1));
endmodule

bind pwrdn_ctrl pwrdn_ctrl_chk #(.DET_W(DET_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_stop(cmd_stop), .cmd_pdm(cmd_pdm),
   .cmd_other(cmd_other), .cmd_done(cmd_done), .state_o(state_o),
   .main_en(main_en), .refresh_en(refresh_en), .rtc_en(rtc_en),
   .det_rst(det_rst), .pdm_reject(pdm_reject), .cmd_exec(cmd_exec)
);

// File: tb/pwrdn_ctrl_bench.sv
module pwrdn_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DET_W      = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_stop = 1'b0, cmd_pdm = 1'b0, cmd_other = 1'b0, cmd_done = 1'b0;
   logic [1:0] state_o;
   logic main_en, refresh_en, rtc_en, pdm_reject, cmd_exec;
   logic [DET_W-1:0] det_rst;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwrdn_ctrl #(.DET_W(DET_W)) u_pwrdn_ctrl (
      .clk(clk), .rst_n(rst_n), .cmd_stop(cmd_stop), .cmd_pdm(cmd_pdm),
      .cmd_other(cmd_other), .cmd_done(cmd_done), .state_o(state_o),
      .main_en(main_en), .refresh_en(refresh_en), .rtc_en(rtc_en),
      .det_rst(det_rst), .pdm_reject(pdm_reject), .cmd_exec(cmd_exec)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Drive a one-cycle strobe set at the falling edge, then sample 1 time unit after the rising edge.
   task automatic step(input logic s, input logic p, input logic o, input logic d);
      @(negedge clk);
      cmd_stop = s; cmd_pdm = p; cmd_other = o; cmd_done = d;
      @(posedge clk);
      #1;
      cmd_stop = 0; cmd_pdm = 0; cmd_other = 0; cmd_done = 0;
   endtask

   task automatic t_reset();
      rst_n = 0;
      repeat (2) @(posedge clk);
      @(negedge clk); rst_n = 1;
      @(posedge clk); #1;
      chk("R1", "state", state_o, 0);
      chk("R1", "main_en", main_en, 1);
      chk("R1", "det_rst", det_rst, 0);
      chk("R1", "reject", pdm_reject, 0);
      chk("R1", "exec", cmd_exec, 0);
   endtask

   task automatic t_enter_pd();
      step(0, 1, 0, 0);
      chk("R2", "state", state_o, 2);
      chk("R2", "main_en", main_en, 0);
      chk("R6", "refresh_en in pd", refresh_en, 1);
      chk("R6", "rtc_en in pd", rtc_en, 1);
   endtask

   task automatic t_wake(input logic s, input logic p, input logic o);
      t_enter_pd();
      step(s, p, o, 0);
      chk("R4", "state after wake", state_o, 0);
      chk("R4", "exec after wake", cmd_exec, 0);
      chk("R5", "det_rst on wake", det_rst, (1 << DET_W) - 1);
      chk("R6", "main_en after wake", main_en, 1);
      step(0, 0, 0, 0);
      chk("R5", "det_rst falls", det_rst, 0);
      chk("R4", "state stays idle", state_o, 0);
   endtask

   task automatic t_busy_stop();
      step(0, 0, 1, 0);
      chk("R8", "state busy", state_o, 1);
      chk("R8", "exec pulse", cmd_exec, 1);
      chk("R6", "main_en busy", main_en, 1);
      step(0, 0, 0, 0);
      chk("R8", "exec falls", cmd_exec, 0);
      step(1, 0, 0, 0);
      chk("R3", "stop to idle", state_o, 0);
   endtask

   task automatic t_busy_done();
      step(0, 0, 1, 0);
      step(0, 0, 0, 1);
      chk("R3", "done to idle", state_o, 0);
   endtask

   task automatic t_reject();
      step(0, 0, 1, 0);
      step(0, 1, 0, 0);
      chk("R7", "state stays busy", state_o, 1);
      chk("R7", "reject pulse", pdm_reject, 1);
      step(0, 0, 0, 0);
      chk("R7", "reject falls", pdm_reject, 0);
      step(1, 1, 0, 0);
      chk("R7", "stop with pdm -> idle", state_o, 0);
      chk("R7", "reject with stop", pdm_reject, 1);
      step(0, 0, 0, 0);
      chk("R7", "no sleep after stop", state_o, 0);
   endtask

   task automatic t_idle_priority();
      step(0, 1, 1, 0);
      chk("R8", "pdm beats other", state_o, 2);
      chk("R8", "no exec", cmd_exec, 0);
      step(1, 0, 0, 0);
      step(0, 0, 0, 0);
   endtask

   task automatic t_busy_other();
      step(0, 0, 1, 0);
      step(0, 0, 1, 0);
      chk("R9", "state busy", state_o, 1);
      chk("R9", "no exec", cmd_exec, 0);
      step(0, 0, 0, 1);
   endtask

   task automatic t_idle_stop();
      step(1, 0, 0, 0);
      chk("R10", "state idle", state_o, 0);
      chk("R10", "no reject", pdm_reject, 0);
      chk("R10", "no exec", cmd_exec, 0);
      chk("R10", "no det_rst", det_rst, 0);
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      t_reset();
      t_enter_pd();
      step(0, 0, 1, 0);
      step(0, 0, 0, 0);
      t_wake(1, 0, 0);
      t_wake(0, 1, 0);
      t_wake(0, 0, 1);
      t_busy_stop();
      t_busy_done();
      t_reject();
      t_idle_priority();
      t_busy_other();
      t_idle_stop();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule